// File: doc/BRIEF.md
# Offset and Gain Calibration Stage

This block sits after the decimation filters of a multi-channel converter and corrects each conversion result with a per-channel offset and gain. A sample arrives with a valid strobe and a channel index. The stage subtracts that channel's 24-bit two's-complement offset. It then scales the difference by that channel's 24-bit unsigned gain, where 400000h means a gain of exactly one. The corrected value leaves three clock cycles later with its own strobe and the same channel index. The result is clamped to the 24-bit signed range. In 16-bit mode the output is cut down to 16 bits.

The calibration words are loaded over a byte-wide write port. Each word takes three writes, high byte first. A small loader state machine only updates a word when the full three-byte sequence finishes, so a sample never uses a half-written value. The loader has three states:

- `LD_IDLE`: no word is being assembled.
- `LD_HI`: the high byte has been captured.
- `LD_MID`: the middle byte has also been captured.

Its transitions are:

- A high-byte write to any calibration word moves the loader to `LD_HI` from every state, restarting assembly for that word.
- In `LD_HI`, a middle-byte write to the same word moves it to `LD_MID`.
- In `LD_MID`, a low-byte write to the same word commits the assembled word and returns to `LD_IDLE`.
- Any other calibration-byte write while in `LD_HI` or `LD_MID` abandons the assembly and returns to `LD_IDLE`.
- Writes outside the calibration map leave the state unchanged.

Top module: `ogc_cal_top`

## Requirements
- R1: After reset, `out_valid` and `out_data` are 0, every offset word is 000000h and every gain word is 400000h, so a 24-bit sample comes out unchanged.
- R2: `out_valid` is high exactly three cycles after `in_valid` was sampled high, and `out_chan` then equals the `in_chan` that came with that sample. Back-to-back samples are accepted every cycle.
- R3: For 24-bit data x on channel n, the output is floor((x − OFS[n]) × GAIN[n] / 2^22). Here OFS is signed and GAIN is unsigned, so the offset is applied before the gain.
- R4: A result above 7FFFFFh is clamped to 7FFFFFh. A result below −800000h is clamped to 800000h. The value never wraps.
- R5: The channel n offset bytes are written at addresses n·8+13h (high), n·8+14h (middle) and n·8+15h (low). The gain bytes are at n·8+16h, n·8+17h and n·8+18h. Writes to any other address (below 13h, above 50h, or n·8+19h / n·8+1Ah) change no word.
- R6: A word changes only on a low-byte write that directly completes a high, middle, low sequence to that same word. A skipped byte, or a byte aimed at a different word, discards the partial value and leaves the word unchanged.
- R7: When `mode16` is 1, bits 15:0 of `in_data` are moved to bits 23:8 (with zeros below) before the offset is applied. `out_data` then carries bits 23:8 of the clamped result, sign-extended to 24 bits.
- R8: A sample on a channel whose `ch_pwdn` bit was set when it entered produces an `out_data` of 0.
- R9: A sample uses the calibration words as they stood in its input cycle. A commit in the same cycle affects only later samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Calibration byte write strobe |
| cfg_addr | input | 8 | Calibration byte address |
| cfg_wdata | input | 8 | Calibration byte value |
| mode16 | input | 1 | 1 selects 16-bit resolution |
| ch_pwdn | input | 8 | Per-channel power-down, bit n for channel n |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 3 | Channel index of the input sample |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Corrected sample strobe |
| out_chan | output | 3 | Channel index of the corrected sample |
| out_data | output | 24 | Corrected, clamped sample |

## Verification
A sample presented in one cycle is due on the outputs three rising edges later. A calibration byte write acts on the next edge, and a completed word first affects the sample presented in the following cycle. The bench drives and samples on falling edges. It keeps a three-deep queue of expected results: at every step it compares the output against the entry pushed three steps earlier, then pushes the expectation for the new input. That expectation is computed from the reference calibration words before that step's write is applied, which is exactly the same-cycle snapshot rule of R9.

// File: rtl/ogc_pkg.sv
package ogc_pkg;

    // data and calibration word widths
    localparam int DATA_W    = 24;
    localparam int CAL_W     = 24;
    localparam int DIFF_W    = DATA_W + 1;
    localparam int PROD_W    = DIFF_W + CAL_W + 1;
    localparam int GAIN_FRAC = CAL_W - 2;
    localparam int SLOT_STRIDE = 8;
    localparam int SLOTS_USED  = 6;

    localparam logic [CAL_W-1:0] GAIN_UNITY = CAL_W'(1) << GAIN_FRAC;

    // byte position inside a calibration word
    localparam logic [1:0] BYTE_HI  = 2'd0;
    localparam logic [1:0] BYTE_MID = 2'd1;
    localparam logic [1:0] BYTE_LO  = 2'd2;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_HI   = 2'd1,
        LD_MID  = 2'd2
    } ld_state_e;

endpackage

// File: rtl/ogc_cfg_loader.sv
module ogc_cfg_loader
    import ogc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h13,
    localparam int CHW = $clog2(NUM_CH)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  logic [7:0]                        cfg_wdata,
    output logic [NUM_CH-1:0][CAL_W-1:0]      ofs_words,
    output logic [NUM_CH-1:0][CAL_W-1:0]      gain_words
);

    localparam int MAP_SPAN = NUM_CH * SLOT_STRIDE;

    // address decode
    logic [ADDR_W-1:0] off;
    logic [2:0]        slot;
    logic              in_map;
    logic              hit;
    logic              wr_gain;
    logic [1:0]        wr_byte;
    logic [CHW:0]      wid;

    always_comb begin
        off     = cfg_addr - BASE_ADDR;
        slot    = off[2:0];
        in_map  = (cfg_addr >= BASE_ADDR) && (int'(off) < MAP_SPAN);
        hit     = cfg_we && in_map && (int'(slot) < SLOTS_USED);
        wr_gain = (slot >= 3'd3);
        wr_byte = wr_gain ? 2'(slot - 3'd3) : 2'(slot);
        wid     = {off[CHW+2:3], wr_gain};
    end

    // assembly state machine
    ld_state_e    st, st_nx;
    logic         commit;
    logic         take_mid;
    logic [CHW:0] tgt;
    logic [7:0]   hi_q, mid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LD_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx    = st;
        commit   = 1'b0;
        take_mid = 1'b0;
        unique case (st)
            LD_IDLE: begin
                if (hit && wr_byte == BYTE_HI) st_nx = LD_HI;
            end
            LD_HI: begin
                if (hit) begin
                    if (wr_byte == BYTE_HI) begin
                        st_nx = LD_HI;
                    end else if (wr_byte == BYTE_MID && wid == tgt) begin
                        st_nx    = LD_MID;
                        take_mid = 1'b1;
                    end else begin
                        st_nx = LD_IDLE;
                    end
                end
            end
            LD_MID: begin
                if (hit) begin
                    if (wr_byte == BYTE_HI) begin
                        st_nx = LD_HI;
                    end else if (wr_byte == BYTE_LO && wid == tgt) begin
                        st_nx  = LD_IDLE;
                        commit = 1'b1;
                    end else begin
                        st_nx = LD_IDLE;
                    end
                end
            end
            default: st_nx = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            mid_q <= '0;
            tgt   <= '0;
        end else begin
            if (hit && wr_byte == BYTE_HI) begin
                hi_q <= cfg_wdata;
                tgt  <= wid;
            end
            if (take_mid) mid_q <= cfg_wdata;
        end
    end

    // per-channel word storage
    for (genvar g = 0; g < NUM_CH; g++) begin : g_words
        localparam logic [CHW:0] WID_OFS  = {CHW'(g), 1'b0};
        localparam logic [CHW:0] WID_GAIN = {CHW'(g), 1'b1};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ofs_words[g]  <= '0;
                gain_words[g] <= GAIN_UNITY;
            end else if (commit) begin
                if (tgt == WID_OFS)  ofs_words[g]  <= {hi_q, mid_q, cfg_wdata};
                if (tgt == WID_GAIN) gain_words[g] <= {hi_q, mid_q, cfg_wdata};
            end
        end
    end

endmodule

// File: rtl/ogc_cal_pipe.sv
module ogc_cal_pipe
    import ogc_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CHW = $clog2(NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode16,
    input  logic [NUM_CH-1:0]             ch_pwdn,
    input  logic                          in_valid,
    input  logic [CHW-1:0]                in_chan,
    input  logic [DATA_W-1:0]             in_data,
    input  logic [NUM_CH-1:0][CAL_W-1:0]  ofs_words,
    input  logic [NUM_CH-1:0][CAL_W-1:0]  gain_words,
    output logic                          out_valid,
    output logic [CHW-1:0]                out_chan,
    output logic [DATA_W-1:0]             out_data
);

    localparam int NARROW_W = 16;
    localparam int PAD_W    = DATA_W - NARROW_W;
    localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] SAT_LO = -SAT_HI - PROD_W'(1);

    // stage A: align and subtract offset
    logic [DATA_W-1:0]        aligned;
    logic [CAL_W-1:0]         ofs_sel;
    logic signed [DIFF_W-1:0] diff_nx;

    always_comb begin
        aligned = mode16 ? {in_data[NARROW_W-1:0], PAD_W'(0)} : in_data;
        ofs_sel = ofs_words[in_chan];
        diff_nx = $signed({aligned[DATA_W-1], aligned}) - $signed({ofs_sel[CAL_W-1], ofs_sel});
    end

    logic                     a_v, a_pw, a_m16;
    logic [CHW-1:0]           a_ch;
    logic signed [DIFF_W-1:0] a_diff;
    logic [CAL_W-1:0]         a_gain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_v    <= 1'b0;
            a_pw   <= 1'b0;
            a_m16  <= 1'b0;
            a_ch   <= '0;
            a_diff <= '0;
            a_gain <= '0;
        end else begin
            a_v    <= in_valid;
            a_pw   <= ch_pwdn[in_chan];
            a_m16  <= mode16;
            a_ch   <= in_chan;
            a_diff <= diff_nx;
            a_gain <= gain_words[in_chan];
        end
    end

    // stage B: multiply by gain and rescale
    logic signed [PROD_W-1:0] prod_nx;
    always_comb prod_nx = a_diff * $signed({1'b0, a_gain});

    logic                     b_v, b_pw, b_m16;
    logic [CHW-1:0]           b_ch;
    logic signed [PROD_W-1:0] b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_v   <= 1'b0;
            b_pw  <= 1'b0;
            b_m16 <= 1'b0;
            b_ch  <= '0;
            b_q   <= '0;
        end else begin
            b_v   <= a_v;
            b_pw  <= a_pw;
            b_m16 <= a_m16;
            b_ch  <= a_ch;
            b_q   <= prod_nx >>> GAIN_FRAC;
        end
    end

    // stage C: clamp, format, zero powered-down channels
    logic [DATA_W-1:0] sat;
    always_comb begin
        if (b_q > SAT_HI)      sat = SAT_HI[DATA_W-1:0];
        else if (b_q < SAT_LO) sat = SAT_LO[DATA_W-1:0];
        else                   sat = b_q[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= b_v;
            out_chan  <= b_ch;
            if (b_pw)       out_data <= '0;
            else if (b_m16) out_data <= {{PAD_W{sat[DATA_W-1]}}, sat[DATA_W-1:PAD_W]};
            else            out_data <= sat;
        end
    end

endmodule

// File: rtl/ogc_cal_top.sv
module ogc_cal_top
    import ogc_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CHW = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              mode16,
    input  logic [NUM_CH-1:0] ch_pwdn,
    input  logic              in_valid,
    input  logic [CHW-1:0]    in_chan,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [CHW-1:0]    out_chan,
    output logic [DATA_W-1:0] out_data
);

    logic [NUM_CH-1:0][CAL_W-1:0] ofs_words;
    logic [NUM_CH-1:0][CAL_W-1:0] gain_words;

    ogc_cfg_loader #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (8),
        .BASE_ADDR (8'h13)
    ) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .ofs_words  (ofs_words),
        .gain_words (gain_words)
    );

    ogc_cal_pipe #(
        .NUM_CH (NUM_CH)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode16     (mode16),
        .ch_pwdn    (ch_pwdn),
        .in_valid   (in_valid),
        .in_chan    (in_chan),
        .in_data    (in_data),
        .ofs_words  (ofs_words),
        .gain_words (gain_words),
        .out_valid  (out_valid),
        .out_chan   (out_chan),
        .out_data   (out_data)
    );

endmodule

// File: rtl/ogc_cal_chk.sv
module ogc_cal_chk #(
    parameter int NUM_CH = 8,
    localparam int CHW = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode16,
    input logic [NUM_CH-1:0] ch_pwdn,
    input logic              in_valid,
    input logic [CHW-1:0]    in_chan,
    input logic              out_valid,
    input logic [CHW-1:0]    out_chan,
    input logic [23:0]       out_data
);

    // edges seen since reset release, saturating at the pipeline depth
    logic [1:0] seen;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    assign warm = (seen == 2'd3);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !warm |-> !out_valid);

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 3)));

    p_chan_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid) |-> (out_chan == $past(in_chan, 3)));

    p_narrow_sext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(mode16, 3)) |-> (out_data[23:16] == {8{out_data[15]}}));

    p_pwdn_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(ch_pwdn[in_chan], 3)) |-> (out_data == 24'd0));

endmodule

bind ogc_cal_top ogc_cal_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode16    (mode16),
    .ch_pwdn   (ch_pwdn),
    .in_valid  (in_valid),
    .in_chan   (in_chan),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data)
);

// File: tb/ogc_cal_top_tb_top.sv
`timescale 1ns/1ps
module ogc_cal_top_tb_top;

    localparam int NCH = 8;
    localparam int CHW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n;
    logic           cfg_we;
    logic [7:0]     cfg_addr, cfg_wdata;
    logic           mode16;
    logic [NCH-1:0] ch_pwdn;
    logic           in_valid;
    logic [CHW-1:0] in_chan;
    logic [23:0]    in_data;
    logic           out_valid;
    logic [CHW-1:0] out_chan;
    logic [23:0]    out_data;

    ogc_cal_top #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mode16(mode16), .ch_pwdn(ch_pwdn),
        .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
        .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
    );

    // reference calibration state
    logic [23:0]    ofs_m [NCH];
    logic [23:0]    gain_m[NCH];
    bit             m16_r;
    logic [NCH-1:0] pw_r;
    int             ld_st;
    int             ld_wid;
    logic [7:0]     ld_hi, ld_mid;

    // expected-result queue, index 2 is due now
    bit          ev[3];
    logic [23:0] ed[3];
    int          ec[3];
    string       et[3];

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    function automatic logic [23:0] model_out(logic [23:0] x, int ch, bit m16, bit pw);
        longint a, d, p, q;
        logic [23:0] r;
        if (pw) return 24'd0;
        if (m16) a = longint'($signed({x[15:0], 8'h00}));
        else     a = longint'($signed(x));
        d = a - longint'($signed(ofs_m[ch]));
        p = d * longint'(gain_m[ch]);
        q = p >>> 22;
        if (q > 64'sd8388607)  q = 64'sd8388607;
        if (q < -64'sd8388608) q = -64'sd8388608;
        r = q[23:0];
        if (m16) return {{8{r[23]}}, r[23:8]};
        return r;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        int off, slot, ch, b, wid;
        bit g;
        if (a < 8'h13) return;
        off = int'(a) - 'h13;
        if (off >= NCH * 8) return;
        slot = off % 8;
        if (slot > 5) return;
        ch  = off / 8;
        g   = (slot >= 3);
        b   = g ? slot - 3 : slot;
        wid = ch * 2 + int'(g);
        if (b == 0) begin
            ld_st = 1; ld_wid = wid; ld_hi = d;
        end else if (b == 1) begin
            if (ld_st == 1 && ld_wid == wid) begin
                ld_st = 2; ld_mid = d;
            end else ld_st = 0;
        end else begin
            if (ld_st == 2 && ld_wid == wid) begin
                if (g) gain_m[ch] = {ld_hi, ld_mid, d};
                else   ofs_m[ch]  = {ld_hi, ld_mid, d};
            end
            ld_st = 0;
        end
    endtask

    task automatic check_due();
        n_vec++;
        if (out_valid !== ev[2]) begin
            n_fail++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", et[2], out_valid, ev[2]);
        end else if (ev[2] && (out_data !== ed[2] || out_chan !== CHW'(ec[2]))) begin
            n_fail++;
            $display("FAIL %s ch/data actual=%0d/%06h expected=%0d/%06h",
                     et[2], out_chan, out_data, ec[2], ed[2]);
        end
    endtask

    task automatic step(input bit v, input int ch, input logic [23:0] x,
                        input bit we, input logic [7:0] a, input logic [7:0] d,
                        input string tag);
        @(negedge clk);
        check_due();
        for (int i = 2; i > 0; i--) begin
            ev[i] = ev[i-1]; ed[i] = ed[i-1]; ec[i] = ec[i-1]; et[i] = et[i-1];
        end
        ev[0] = v;
        ec[0] = ch;
        et[0] = v ? tag : "R2";
        ed[0] = v ? model_out(x, ch, m16_r, pw_r[ch]) : 24'd0;
        if (we) model_write(a, d);
        in_valid  = v;
        in_chan   = CHW'(ch);
        in_data   = x;
        cfg_we    = we;
        cfg_addr  = a;
        cfg_wdata = d;
        mode16    = m16_r;
        ch_pwdn   = pw_r;
    endtask

    task automatic sample(input int ch, input logic [23:0] x, input string tag);
        step(1'b1, ch, x, 1'b0, 8'h00, 8'h00, tag);
    endtask

    task automatic idle();
        step(1'b0, 0, 24'd0, 1'b0, 8'h00, 8'h00, "R2");
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        step(1'b0, 0, 24'd0, 1'b1, a, d, "R2");
    endtask

    task automatic wr_word(input int ch, input bit g, input logic [23:0] val);
        logic [7:0] base;
        base = 8'(8'h13 + ch * 8 + (g ? 3 : 0));
        wr_byte(base, val[23:16]);
        wr_byte(base + 8'd1, val[15:8]);
        wr_byte(base + 8'd2, val[7:0]);
    endtask

    task automatic rand_samples(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 3) == 0) idle();
            else sample(int'($urandom_range(0, NCH - 1)), 24'($urandom()), tag);
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        mode16 = 1'b0; ch_pwdn = '0; in_valid = 1'b0; in_chan = '0; in_data = '0;
        m16_r = 1'b0; pw_r = '0; ld_st = 0; ld_wid = 0; ld_hi = '0; ld_mid = '0;
        for (int i = 0; i < NCH; i++) begin
            ofs_m[i] = 24'h000000; gain_m[i] = 24'h400000;
        end
        for (int i = 0; i < 3; i++) begin
            ev[i] = 1'b0; ed[i] = '0; ec[i] = 0; et[i] = "R2";
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        n_vec++;
        if (out_valid !== 1'b0 || out_data !== 24'd0) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual=%0b/%06h expected=0/000000", out_valid, out_data);
        end
        rst_n = 1'b1;

        // R1: unity pass-through
        sample(0, 24'h7FFFFF, "R1");
        sample(7, 24'h800000, "R1");
        sample(3, 24'h000001, "R1");
        rand_samples(40, "R1");

        // R5: writes outside the map, one interleaved in a valid sequence
        wr_byte(8'h12, 8'hAA);
        wr_byte(8'h19, 8'h55);
        wr_byte(8'h1A, 8'h77);
        wr_byte(8'h51, 8'h12);
        wr_byte(8'h00, 8'hFF);
        for (int c = 0; c < NCH; c++) sample(c, 24'h123456, "R5");
        wr_byte(8'h13, 8'h00);
        wr_byte(8'h19, 8'h99);
        wr_byte(8'h14, 8'h01);
        wr_byte(8'h15, 8'h00);
        wr_word(3, 1'b0, 24'h000100);
        for (int c = 0; c < NCH; c++) sample(c, 24'h001000, "R5");

        // R6: broken sequences leave words untouched, complete one commits
        wr_byte(8'h26, 8'h20);
        wr_byte(8'h28, 8'h00);
        sample(2, 24'h100000, "R6");
        wr_byte(8'h26, 8'h20);
        wr_byte(8'h27, 8'h00);
        sample(2, 24'h100000, "R6");
        wr_byte(8'h30, 8'h00);
        sample(2, 24'h100000, "R6");
        wr_byte(8'h23, 8'h11);
        wr_byte(8'h26, 8'h20);
        wr_byte(8'h27, 8'h00);
        wr_byte(8'h28, 8'h00);
        sample(2, 24'h100000, "R6");
        sample(2, 24'hF00000, "R6");

        // R9: commit in the same cycle as a sample
        wr_byte(8'h1B, 8'h00);
        wr_byte(8'h1C, 8'h40);
        step(1'b1, 1, 24'h050000, 1'b1, 8'h1D, 8'h00, "R9");
        sample(1, 24'h050000, "R9");

        // R4: clamping at both limits
        wr_word(4, 1'b1, 24'hFFFFFF);
        wr_word(4, 1'b0, 24'h000000);
        sample(4, 24'h7FFFFF, "R4");
        sample(4, 24'h800000, "R4");
        wr_word(5, 1'b0, 24'h800000);
        sample(5, 24'h7FFFFF, "R4");
        wr_word(5, 1'b0, 24'h7FFFFF);
        sample(5, 24'h800000, "R4");
        wr_word(6, 1'b1, 24'h000000);
        sample(6, 24'h7FFFFF, "R4");

        // R3: random words and samples
        for (int rnd = 0; rnd < 4; rnd++) begin
            for (int c = 0; c < NCH; c++) begin
                wr_word(c, 1'b0, 24'($urandom()));
                wr_word(c, 1'b1, 24'($urandom_range(0, 24'hFFFFFF)));
            end
            rand_samples(250, "R3");
        end
        for (int c = 0; c < NCH; c++) begin
            wr_word(c, 1'b0, 24'($urandom_range(0, 24'h000FFF)));
            wr_word(c, 1'b1, 24'($urandom_range(24'h300000, 24'h500000)));
        end
        rand_samples(150, "R3");

        // R7: 16-bit mode
        m16_r = 1'b1;
        sample(0, 24'hAB7FFF, "R7");
        sample(1, 24'h008000, "R7");
        rand_samples(200, "R7");
        m16_r = 1'b0;

        // R8: powered-down channels
        for (int k = 0; k < 4; k++) begin
            pw_r  = NCH'($urandom());
            m16_r = k[0];
            rand_samples(60, "R8");
        end
        pw_r = '0; m16_r = 1'b0;

        // R2: back-to-back stream with no gaps
        for (int i = 0; i < 50; i++) sample(i % NCH, 24'($urandom()), "R2");

        repeat (4) idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule